// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a running BCD time of day (seconds, minutes, hours, day of month) and raises an alarm when it matches a programmed alarm setting. The setting is held in four field registers. Each field register has its own "don't care" mask bit. The pattern of the four mask bits picks the alarm's repeat period: once on a given date, or every day, every hour, every minute or every second. Any mask pattern outside the defined set falls back to firing every second, so that software sees at once that the setting is wrong.

The comparison happens only on cycles where the one-second tick is high. A match sets a sticky alarm flag, and a host read strobe clears it. An active-low, open-drain interrupt line is pulled low while the flag is set, subject to two enables. A general enable is needed in all cases. A second enable is also needed while the system runs from its backup battery, so that the alarm can serve as a wake-up source.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, `alarm_flag` is 0, the interrupt line is released (high-Z), all field values and mask bits are 0, and both enables are 0.
- R2: The write port stores a field register when `cfg_addr` is 0 (seconds), 1 (minutes), 2 (hours) or 3 (date). `cfg_wdata[7]` is the field's mask bit (1 = ignore the field) and `cfg_wdata[6:0]` is the BCD match value. With all four mask bits set to 1, every tick sets the flag, whatever the time.
- R3: Mask pattern {date,hour,min,sec} = 1110 sets the flag on a tick only when the seconds match.
- R4: Mask pattern 1100 sets the flag only when both the minutes and the seconds match.
- R5: Mask pattern 1000 sets the flag only when the hours, minutes and seconds all match.
- R6: Mask pattern 0000 sets the flag only when the date, hours, minutes and seconds all match.
- R7: Any mask pattern other than 1111, 1110, 1100, 1000 and 0000 makes every tick set the flag.
- R8: The flag is set only by a clock edge at which `sec_tick` is 1. A matching time without a tick has no effect.
- R9: A clock edge with `flag_rd` = 1 clears the flag. If a setting match occurs at the same edge, the flag stays 1.
- R10: A write to address 4 sets the general enable from `cfg_wdata[1]` and the backup enable from `cfg_wdata[0]`. On main power (`on_battery` = 0), the interrupt line is driven low exactly while the flag is 1 and the general enable is 1.
- R11: On battery (`on_battery` = 1), the interrupt line is driven low only while the flag is 1 and both enables are 1. Otherwise it is released.
- R12: Once set, the flag holds through any number of cycles until a read strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second; the comparison is made on this cycle |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_date | input | 8 | Current day of month, BCD |
| on_battery | input | 1 | 1 while running from backup battery |
| cfg_we | input | 1 | Write strobe for the setting registers |
| cfg_addr | input | 3 | 0..3 alarm fields (sec, min, hour, date), 4 enables |
| cfg_wdata | input | 8 | Write data |
| flag_rd | input | 1 | Host read of the flag; clears it |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Open-drain interrupt: 0 when asserted, high-Z otherwise |

## Verification
A new match and the host's read-to-clear can land on the same clock edge. The correct outcome is that the flag survives, so the new event is not lost. The bench first leaves the flag set and then, within a single cycle, raises both the tick (with a matching time) and the read strobe. It expects the flag to read 1 after that edge. It also checks that a read alone, with no tick, returns the flag to 0. The interrupt line is judged at the same points through a pulled-up net.

// File: rtl/tod_alarm_pkg.sv
// Package: shared widths, alarm mode type and the mask-pattern decoder.
// Assumes field order sec=0, min=1, hour=2, date=3 everywhere.
package tod_alarm_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 4;
    localparam int VAL_W      = FIELD_W - 1;

    typedef enum logic [2:0] {
        MODE_EVERY_SEC,
        MODE_SEC,
        MODE_MIN_SEC,
        MODE_HMS,
        MODE_DHMS
    } alarm_mode_e;

    // Map the mask pattern {date,hour,min,sec} to a repeat mode; unknown -> every second.
    function automatic alarm_mode_e decode_mode(input logic [3:0] msk);
        case (msk)
            4'b1111: return MODE_EVERY_SEC;
            4'b1110: return MODE_SEC;
            4'b1100: return MODE_MIN_SEC;
            4'b1000: return MODE_HMS;
            4'b0000: return MODE_DHMS;
            default: return MODE_EVERY_SEC;
        endcase
    endfunction

    // Which fields a mode requires to match, bit n = field n.
    function automatic logic [3:0] fields_needed(input alarm_mode_e md);
        case (md)
            MODE_SEC:     return 4'b0001;
            MODE_MIN_SEC: return 4'b0011;
            MODE_HMS:     return 4'b0111;
            MODE_DHMS:    return 4'b1111;
            default:      return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regs.sv
// Setting registers: one masked field register per time field plus an enable register.
// Assumes addresses 0..NF-1 select fields and address NF selects the enables;
// other addresses are ignored.
module alarm_regs #(
    parameter int FW     = 8,
    parameter int NF     = 4,
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [FW-1:0]        wdata,
    output logic [NF-1:0][FW-2:0] field_val,
    output logic [NF-1:0]        field_mask,
    output logic                 en_main,
    output logic                 en_backup
);
    localparam int EN_ADDR = NF;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_field
            // Load one field's value and mask on a write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    field_val[gi]  <= '0;
                    field_mask[gi] <= 1'b0;
                end else if (we && addr == ADDR_W'(gi)) begin
                    field_val[gi]  <= wdata[FW-2:0];
                    field_mask[gi] <= wdata[FW-1];
                end
            end
        end
    endgenerate

    // Load both interrupt enables on a write to the enable address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_main   <= 1'b0;
            en_backup <= 1'b0;
        end else if (we && addr == ADDR_W'(EN_ADDR)) begin
            en_main   <= wdata[1];
            en_backup <= wdata[0];
        end
    end

endmodule

// File: rtl/alarm_match.sv
// Combinational comparator: per-field equality, mode decode, masked reduction.
// Assumes current-time fields are BCD with the top bit 0.
module alarm_match
    import tod_alarm_pkg::*;
#(
    parameter int FW = 8,
    parameter int NF = 4
) (
    input  logic [NF-1:0][FW-1:0] cur_time,
    input  logic [NF-1:0][FW-2:0] field_val,
    input  logic [NF-1:0]         field_mask,
    output logic                  hit,
    output logic                  every_sec
);
    logic [NF-1:0] field_eq;
    logic [3:0]    need;
    alarm_mode_e   mode;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_cmp
            // Compare one field, the zero top bit included.
            always_comb field_eq[gi] = (cur_time[gi] == {1'b0, field_val[gi]});
        end
    endgenerate

    // Decode the mask pattern and reduce the required field matches.
    always_comb begin
        mode      = decode_mode(field_mask);
        need      = fields_needed(mode);
        hit       = &(field_eq | ~need[NF-1:0]);
        every_sec = (mode == MODE_EVERY_SEC);
    end

endmodule

// File: rtl/alarm_flag_irq.sv
// Sticky alarm flag with read-to-clear and power-aware interrupt gating.
// Assumes a set on the tick has priority over a clear in the same cycle.
module alarm_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic hit,
    input  logic flag_rd,
    input  logic en_main,
    input  logic en_backup,
    input  logic on_battery,
    output logic flag,
    output logic irq_assert
);
    logic set_now;

    // Set request: a match seen on the once-per-second tick.
    always_comb set_now = sec_tick && hit;

    // Flag register: set wins, read clears, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_now) flag <= 1'b1;
        else if (flag_rd) flag <= 1'b0;
    end

    // Interrupt gating by enables and power source.
    always_comb irq_assert = flag && en_main && (!on_battery || en_backup);

endmodule

// File: rtl/tod_alarm_unit.sv
// Top: masked time-of-day alarm with sticky flag and open-drain interrupt.
// Assumes one-cycle sec_tick pulses and a stable time during the tick.
module tod_alarm_unit
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic               on_battery,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [FIELD_W-1:0] cfg_wdata,
    input  logic               flag_rd,
    output logic               alarm_flag,
    output logic               irq_n
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_time;
    logic [NUM_FIELDS-1:0][VAL_W-1:0]   field_val;
    logic [NUM_FIELDS-1:0]              field_mask;
    logic en_main, en_backup, hit, every_sec, irq_assert;

    // Gather the time fields in register order.
    always_comb cur_time = {cur_date, cur_hour, cur_min, cur_sec};

    alarm_regs #(.FW(FIELD_W), .NF(NUM_FIELDS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .field_val(field_val), .field_mask(field_mask),
        .en_main(en_main), .en_backup(en_backup)
    );

    alarm_match #(.FW(FIELD_W), .NF(NUM_FIELDS)) u_match (
        .cur_time(cur_time), .field_val(field_val), .field_mask(field_mask),
        .hit(hit), .every_sec(every_sec)
    );

    alarm_flag_irq u_flag (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hit(hit), .flag_rd(flag_rd),
        .en_main(en_main), .en_backup(en_backup), .on_battery(on_battery),
        .flag(alarm_flag), .irq_assert(irq_assert)
    );

    // Open-drain output: pull low when asserted, release otherwise.
    assign irq_n = irq_assert ? 1'b0 : 1'bz;

endmodule

// File: rtl/tod_alarm_chk.sv
// Checker: temporal properties of the alarm unit, bound to the top module.
module tod_alarm_chk (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic flag_rd,
    input logic alarm_flag,
    input logic every_sec,
    input logic irq_assert,
    input logic en_main,
    input logic en_backup,
    input logic on_battery
);
    assert_set_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !sec_tick) |=> !alarm_flag);

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_rd) |=> alarm_flag);

    assert_every_tick_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && every_sec) |=> alarm_flag);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_assert |-> (alarm_flag && en_main));

    assert_irq_backup_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_assert && on_battery) |-> en_backup);

endmodule

bind tod_alarm_unit tod_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .flag_rd(flag_rd),
    .alarm_flag(alarm_flag), .every_sec(every_sec), .irq_assert(irq_assert),
    .en_main(en_main), .en_backup(en_backup), .on_battery(on_battery)
);

// File: tb/tod_alarm_unit_tb.sv
`timescale 1ns/1ps
module tod_alarm_unit_tb;
    logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, on_battery = 1'b0;
    logic cfg_we = 1'b0, flag_rd = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0, cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic alarm_flag;
    wire  irq_line;
    pullup (irq_line);

    always #2 clk = ~clk;

    tod_alarm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_date(cur_date), .on_battery(on_battery), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .flag_rd(flag_rd),
        .alarm_flag(alarm_flag), .irq_n(irq_line)
    );

    typedef struct {
        int    due;
        bit    flag;
        bit    irq_low;
        string tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0, cyc = 0;
    bit m_flag = 0, m_ae = 0, m_abe = 0, done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard monitor: compare every due item at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            bit   act_low;
            e = q.pop_front();
            act_low = (irq_line === 1'b0);
            total++;
            if (alarm_flag !== e.flag || act_low != e.irq_low) begin
                bad++;
                $display("FAIL %s: flag=%0b irq_low=%0b expected flag=%0b irq_low=%0b",
                         e.tag, alarm_flag, act_low, e.flag, e.irq_low);
            end
        end
    end

    function automatic bit model_irq();
        return m_flag && m_ae && (!on_battery || m_abe);
    endfunction

    function automatic void push(string tag);
        exp_t e;
        e.due = cyc + 1; e.flag = m_flag; e.irq_low = model_irq(); e.tag = tag;
        q.push_back(e);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 3'd4) begin m_ae = d[1]; m_abe = d[0]; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] d, h, m, s);
        cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
    endtask

    // Driver: one tick (optionally with a read), pushing the expected result.
    task automatic tick(input bit match, input bit rd, input string tag);
        @(negedge clk);
        sec_tick = 1'b1; flag_rd = rd;
        if (match) m_flag = 1; else if (rd) m_flag = 0;
        push(tag);
        @(negedge clk);
        sec_tick = 1'b0; flag_rd = 1'b0;
    endtask

    task automatic rd_flag(input string tag);
        @(negedge clk);
        flag_rd = 1'b1; m_flag = 0;
        push(tag);
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        push(tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        push("R1 reset state");
        @(negedge clk); rst_n = 1'b1;
        idle("R1 after reset release");

        // every second, general enable on
        wr(3'd4, 8'h02);
        for (int i = 0; i < 4; i++) wr(3'(i), 8'h80);
        set_time(8'h12, 8'h07, 8'h44, 8'h03);
        tick(1, 0, "R2 all masked fires");
        rd_flag("R9 read clears");
        set_time(8'h28, 8'h21, 8'h05, 8'h59);
        tick(1, 0, "R2 all masked second time");
        rd_flag("R9 read clears again");

        // seconds only
        wr(3'd0, 8'h25);
        idle("R8 no tick no set");
        set_time(8'h01, 8'h00, 8'h00, 8'h25);
        repeat (3) idle("R8 matching time without tick");
        set_time(8'h01, 8'h00, 8'h00, 8'h24);
        tick(0, 0, "R3 seconds mismatch");
        set_time(8'h19, 8'h13, 8'h37, 8'h25);
        tick(1, 0, "R3 seconds match");
        rd_flag("R9 clear");

        // minutes and seconds
        wr(3'd0, 8'h10); wr(3'd1, 8'h30);
        set_time(8'h01, 8'h02, 8'h31, 8'h10);
        tick(0, 0, "R4 minute mismatch");
        set_time(8'h01, 8'h02, 8'h30, 8'h11);
        tick(0, 0, "R4 second mismatch");
        set_time(8'h05, 8'h09, 8'h30, 8'h10);
        tick(1, 0, "R4 match");
        rd_flag("R9 clear");

        // hours, minutes, seconds
        wr(3'd2, 8'h17);
        set_time(8'h01, 8'h18, 8'h30, 8'h10);
        tick(0, 0, "R5 hour mismatch");
        set_time(8'h22, 8'h17, 8'h30, 8'h10);
        tick(1, 0, "R5 match");
        rd_flag("R9 clear");

        // full date match
        wr(3'd3, 8'h09);
        set_time(8'h10, 8'h17, 8'h30, 8'h10);
        tick(0, 0, "R6 date mismatch");
        set_time(8'h09, 8'h17, 8'h30, 8'h10);
        tick(1, 0, "R6 full match");

        // sticky flag
        repeat (4) idle("R12 flag holds");
        rd_flag("R9 clear");

        // undefined pattern 0101 -> every second
        wr(3'd0, 8'h90); wr(3'd2, 8'h97);
        set_time(8'h31, 8'h03, 8'h59, 8'h42);
        tick(1, 0, "R7 undefined mask fires");
        rd_flag("R9 clear");
        wr(3'd0, 8'h10); wr(3'd1, 8'hB0); wr(3'd2, 8'h17);
        tick(1, 0, "R7 pattern 0010 fires");

        // same-edge set and clear
        tick(1, 1, "R9 set wins over read");
        rd_flag("R9 clear after collision");

        // enables on main power
        wr(3'd4, 8'h00);
        tick(1, 0, "R10 flag with enable off");
        wr(3'd4, 8'h02);
        idle("R10 enable on drives low");

        // battery
        @(negedge clk); on_battery = 1'b1;
        idle("R11 battery without backup enable");
        wr(3'd4, 8'h03);
        idle("R11 battery with both enables");
        wr(3'd4, 8'h01);
        idle("R11 battery backup enable only");
        @(negedge clk); on_battery = 1'b0;
        idle("R10 main power enable off");
        rd_flag("R9 final clear");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule